// File: doc/BRIEF.md
# Frame-Timed Multi-Channel Sample Serializer

This block sits at the digital output side of a simultaneous-sampling multi-channel converter. It takes one 24-bit two's-complement word per channel from a parallel source and shifts the words out serially, timed by a frame clock and a serial clock that an external receiver drives. The receiver runs both clocks. A rising edge of the frame clock, seen at a rising serial-clock edge, starts a frame. From that point the block sends each word most significant bit first. Outputs change after serial-clock falling edges, so the receiver samples them on rising edges.

Two output arrangements are available, and the choice is latched at each frame start. In time-division mode every channel word goes out on line 0, lowest channel first. After the local words, line 0 carries the daisy-chain input. The chain input is shifted through the same register chain, so several devices can be cascaded on one line. In discrete mode each channel has its own line, and the chain input is not used. Channels can be powered down one at a time, and a powered-down channel sends zeros in its slot. A sample set presented with the valid strobe is held in a staging store. It is moved into the shifters only at a frame start, so a frame never mixes two conversions.

All logic runs on the master clock. The serial and frame clocks are treated as level inputs, and their edges are found by comparing each with its registered copy. The serial clock must therefore run at one half of the master clock or slower.

Top module: `tdm_frame_serializer`

## Requirements
- R1: After reset every output line is 0, and stays 0 whatever the daisy-chain input does until the first frame start.
- R2: A frame starts only at a serial-clock rising edge where the frame clock is 1 and was 0 at the previous serial-clock rising edge. Holding the frame clock high for further rising edges does not restart the frame.
- R3: Stream bit i (bit 0 is the first word's MSB) is valid at the (i+1)-th serial-clock rising edge after the frame-start rising edge. Outputs change only after serial-clock falling edges, and the first falling edge after the start does not advance the stream.
- R4: With tdm_sel=1, line 0 carries channel 0, 1, ... NCH-1 in that order, 24 bits each, MSB first. Lines 1..NCH-1 are 0.
- R5: In time-division mode, after the NCH*24 local bits, line 0 carries the chain-input bits. The chain input is sampled at each advancing serial-clock falling edge, and the bit taken at the first such edge comes first.
- R6: With tdm_sel=0, line k carries channel k's word MSB first for stream bits 0..23 and then 0 for the rest of the frame. The chain input has no effect.
- R7: A channel whose power-down bit is 1 at the frame start sends 24 zero bits in its slot. The other slots are unchanged.
- R8: Samples, power-down bits and tdm_sel are taken only at the frame start. A valid strobe or a change of these inputs during a frame leaves the current frame unchanged and takes effect at the next frame start.
- R9: If no valid strobe arrives between two frame starts, the previous sample set is sent again.
- R10: The output stream is the same for serial-clock rates of 1/2, 1/4 and 1/8 of the master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Continuously running serial clock, at most clk/2 |
| fsync | input | 1 | Frame clock driven by the receiver |
| smp_valid | input | 1 | Strobe: smp_data holds a new sample set |
| smp_data | input | NCH*24 | Channel k word at bits [k*24+23 : k*24], two's complement |
| pwdn | input | NCH | Per-channel power-down, 1 = channel sends zeros |
| tdm_sel | input | 1 | 1 = time-division on line 0, 0 = one line per channel |
| din | input | 1 | Daisy-chain serial input |
| dout | output | NCH | Serial data lines; line 0 is the shared time-division line |

## Verification
The assertions assume that the serial clock holds each level for at least one master-clock cycle, so that every serial-clock edge appears as exactly one master-clock cycle with a rising or falling indication. They also assume that the frame clock changes only while the serial clock is low. The bench makes each serial-clock half period 1, 2 or 4 master-clock cycles and changes every input on master-clock falling edges. It moves the frame clock only at serial-clock falling edges and the chain input only at rising edges. Sample, power-down and mode changes are applied either between frames or at a rising edge inside a frame.

// File: rtl/tdmser_pkg.sv
package tdmser_pkg;
    localparam int WORD_W = 24;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/tdmser_edge.sv
module tdmser_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic fsync,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic frame_start
);
    typedef struct packed {
        logic sclk;
        logic fs_at_rise;
    } edge_st_t;

    edge_st_t st_d, st_q;

    assign sclk_rise   = sclk & ~st_q.sclk;
    assign sclk_fall   = ~sclk & st_q.sclk;
    assign frame_start = sclk_rise & fsync & ~st_q.fs_at_rise;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = sclk;
        if (sclk_rise) begin
            st_d.fs_at_rise = fsync;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tdmser_stage.sv
module tdmser_stage #(
    parameter int NCH = 4,
    parameter int W   = tdmser_pkg::WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [NCH*W-1:0] smp_data,
    input  logic [NCH-1:0]   pwdn,
    input  logic             tdm_sel,
    input  logic             frame_start,
    output logic [NCH*W-1:0] load_words,
    output logic [NCH-1:0]   pwdn_q,
    output logic             tdm_q
);
    typedef struct packed {
        logic [NCH*W-1:0] pend;
        logic [NCH-1:0]   pwdn;
        logic             tdm;
    } stage_st_t;

    stage_st_t st_d, st_q;

    // words handed to the shifters: powered-down channels forced to zero
    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            load_words[k*W +: W] = pwdn[k] ? '0 : st_q.pend[k*W +: W];
        end
    end

    always_comb begin
        st_d = st_q;
        if (smp_valid) begin
            st_d.pend = smp_data;
        end
        if (frame_start) begin
            st_d.pwdn = pwdn;
            st_d.tdm  = tdm_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwdn_q = st_q.pwdn;
    assign tdm_q  = st_q.tdm;
endmodule

// File: rtl/tdmser_seq.sv
module tdmser_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_fall,
    input  logic frame_start,
    output logic shift,
    output logic active
);
    typedef struct packed {
        logic active;
        logic skip;
    } seq_st_t;

    seq_st_t st_d, st_q;

    // the first falling edge after a start keeps the MSB on the line
    assign shift  = sclk_fall & st_q.active & ~st_q.skip & ~frame_start;
    assign active = st_q.active;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.active = 1'b1;
            st_d.skip   = 1'b1;
        end else if (sclk_fall && st_q.active) begin
            st_d.skip = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tdmser_lane.sv
module tdmser_lane #(
    parameter int W = tdmser_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    input  logic         shift_in,
    output logic         msb
);
    typedef struct packed {
        logic [W-1:0] sr;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sr = load_word;
        end else if (shift) begin
            st_d.sr = {st_q.sr[W-2:0], shift_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msb = st_q.sr[W-1];
endmodule

// File: rtl/tdm_frame_serializer.sv
module tdm_frame_serializer #(
    parameter int NCH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sclk,
    input  logic                          fsync,
    input  logic                          smp_valid,
    input  logic [NCH*tdmser_pkg::WORD_W-1:0] smp_data,
    input  logic [NCH-1:0]                pwdn,
    input  logic                          tdm_sel,
    input  logic                          din,
    output logic [NCH-1:0]                dout
);
    localparam int W = tdmser_pkg::WORD_W;

    logic             sclk_rise;
    logic             sclk_fall;
    logic             frame_start;
    logic             shift;
    logic             active;
    logic             tdm_q;
    logic [NCH-1:0]   pwdn_q;
    logic [NCH*W-1:0] load_words;
    logic [NCH-1:0]   lane_msb;

    tdmser_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .fsync      (fsync),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .frame_start(frame_start)
    );

    tdmser_stage #(.NCH(NCH), .W(W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .pwdn       (pwdn),
        .tdm_sel    (tdm_sel),
        .frame_start(frame_start),
        .load_words (load_words),
        .pwdn_q     (pwdn_q),
        .tdm_q      (tdm_q)
    );

    tdmser_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_fall  (sclk_fall),
        .frame_start(frame_start),
        .shift      (shift),
        .active     (active)
    );

    // In time-division mode the lanes form one chain: lane k+1 feeds lane k,
    // the chain input feeds the last lane, lane 0 drives the shared line.
    for (genvar k = 0; k < NCH; k++) begin : g_lane
        logic sin;
        if (k == NCH-1) begin : g_tail
            assign sin = tdm_q ? din : 1'b0;
        end else begin : g_link
            assign sin = tdm_q ? lane_msb[k+1] : 1'b0;
        end

        tdmser_lane #(.W(W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (frame_start),
            .load_word(load_words[k*W +: W]),
            .shift    (shift),
            .shift_in (sin),
            .msb      (lane_msb[k])
        );

        if (k == 0) begin : g_shared
            assign dout[k] = lane_msb[k];
        end else begin : g_own
            assign dout[k] = tdm_q ? 1'b0 : lane_msb[k];
        end

        AST_PWDN_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(frame_start) && !tdm_q && pwdn_q[k] |-> dout[k] == 1'b0)
            else $error("powered-down line not zero"); // R7

        AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(frame_start) && !tdm_q && !pwdn_q[k]
            |-> dout[k] == $past(load_words[k*W+W-1]))
            else $error("MSB not presented after frame start"); // R3
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> dout == '0)
        else $error("output active before first frame"); // R1

    AST_CHANGE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(sclk_fall) && !$past(frame_start) |-> $stable(dout))
        else $error("output changed without falling edge or start"); // R3
endmodule

// File: tb/tdm_frame_serializer_bench.sv
module tdm_frame_serializer_bench;
    localparam int NCH = 4;
    localparam int W   = 24;
    localparam int L   = NCH*W;
    localparam int NB  = 130;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             sclk = 1'b0;
    logic             fsync = 1'b0;
    logic             smp_valid = 1'b0;
    logic [NCH*W-1:0] smp_data = '0;
    logic [NCH-1:0]   pwdn = '0;
    logic             tdm_sel = 1'b0;
    logic             din = 1'b0;
    logic [NCH-1:0]   dout;

    tdm_frame_serializer #(.NCH(NCH)) u_tdm_frame_serializer (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync),
        .smp_valid(smp_valid), .smp_data(smp_data), .pwdn(pwdn),
        .tdm_sel(tdm_sel), .din(din), .dout(dout)
    );

    typedef struct {
        logic [NCH-1:0] v;
        string          tag;
        int             idx;
    } exp_t;

    exp_t     expq[$];
    int       n_chk = 0;
    int       n_fail = 0;
    event     samp_ev;
    logic [W-1:0] stg_w [NCH];
    logic [W-1:0] nxt_w [NCH];
    logic     din_pat [256];

    // monitor: pops one expected vector per receiver sampling edge
    always @(samp_ev) begin
        exp_t e;
        n_chk++;
        if (expq.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard empty: actual %b expected none", dout);
        end else begin
            e = expq.pop_front();
            if (dout !== e.v) begin
                n_fail++;
                $display("FAIL %s bit %0d: actual %b expected %b", e.tag, e.idx, dout, e.v);
            end
        end
    end

    task automatic half(input int div);
        repeat (div/2) @(negedge clk);
    endtask

    task automatic set_din(input int seed);
        for (int j = 0; j < 256; j++) din_pat[j] = (((j*5 + seed) % 3) == 0);
    endtask

    task automatic load_set(input int seed);
        @(negedge clk);
        for (int k = 0; k < NCH; k++) begin
            stg_w[k] = 24'(seed*24'h1357B1 + k*24'h2468AC + 24'h800000*(k == 0 ? 1 : 0));
            smp_data[k*W +: W] = stg_w[k];
        end
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // driver side: expected stream from the requirements
    task automatic push_frame(input logic tdm, input logic [NCH-1:0] pd, input string tag);
        for (int i = 0; i < NB; i++) begin
            exp_t e;
            e.v = '0;
            e.tag = tag;
            e.idx = i;
            if (tdm) begin
                if (i < L) e.v[0] = pd[i/W] ? 1'b0 : stg_w[i/W][W-1-(i%W)];
                else       e.v[0] = din_pat[i-L];
            end else begin
                for (int k = 0; k < NCH; k++)
                    if (i < W) e.v[k] = pd[k] ? 1'b0 : stg_w[k][W-1-i];
            end
            expq.push_back(e);
        end
    endtask

    task automatic run_frame(input int div, input bit hold, input bit mid, input string tag);
        push_frame(tdm_sel, pwdn, tag);
        fsync = 1'b1;
        half(div); sclk = 1'b1;           // frame-start rising edge
        half(div); sclk = 1'b0;           // non-advancing falling edge
        if (!hold) fsync = 1'b0;
        for (int r = 1; r <= NB; r++) begin
            half(div);
            sclk = 1'b1;
            din  = din_pat[r-1];
            if (mid && r == 10) begin
                for (int k = 0; k < NCH; k++) smp_data[k*W +: W] = nxt_w[k];
                smp_valid = 1'b1;
                pwdn      = 4'b1001;
                tdm_sel   = 1'b0;
            end
            -> samp_ev;
            half(div);
            sclk = 1'b0;
            smp_valid = 1'b0;
            if (hold && r == 2) fsync = 1'b0;
        end
        if (mid) for (int k = 0; k < NCH; k++) stg_w[k] = nxt_w[k];
    endtask

    task automatic idle_periods(input int div, input int n);
        for (int r = 0; r < n; r++) begin
            exp_t e;
            e.v = '0; e.tag = "R1 idle"; e.idx = r;
            expq.push_back(e);
            half(div);
            sclk = 1'b1;
            din  = ~din;
            -> samp_ev;
            half(div);
            sclk = 1'b0;
        end
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) stg_w[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (dout !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: actual %b expected 0", dout);
        end
        idle_periods(2, 8);                           // R1 chain input ignored

        set_din(1); load_set(3); tdm_sel = 1'b1; pwdn = '0;
        run_frame(2, 0, 0, "R3 R4 R5 tdm");
        set_din(2);
        run_frame(4, 0, 0, "R9 repeat");              // no new strobe
        set_din(0); load_set(7); tdm_sel = 1'b0;
        run_frame(8, 0, 0, "R6 R10 discrete");
        tdm_sel = 1'b1; pwdn = 4'b0010;
        run_frame(4, 0, 0, "R7 pwdn");
        pwdn = '0; set_din(1);
        for (int k = 0; k < NCH; k++) nxt_w[k] = 24'(24'hA5A5A5 ^ (k*24'h111111));
        run_frame(2, 0, 1, "R8 mid-frame change");
        run_frame(2, 0, 0, "R8 next frame");          // discrete, pwdn 1001, new words
        tdm_sel = 1'b1; pwdn = '0; set_din(2);
        run_frame(2, 1, 0, "R2 fsync held");
        n_chk++;
        if (expq.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", expq.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule